// File: doc/BRIEF.md
# Chainable 24-Bit Serial Command Receiver

This block is the device-side serial front end of a multi-channel converter's control port. The host lowers an active-low select, then clocks serial data in. The block samples data on each falling edge of the serial clock, most significant bit first. After exactly 24 bits it sends a one-cycle strobe to the register block that follows it. The strobe carries an 8-bit command code and a 16-bit payload.

A ready output lets several devices share the same clock and data lines. That output is wired to the select input of the next device. It goes low in the cycle the frame completes, so the next device takes the following 24 bits of the same burst. Devices are served in chain order, starting next to the host. A device that should stay unchanged during a burst is sent a no-op. The ready output can be switched off by software, and it then stays high.

The select, clock and data inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies.

Top module: `chain_cmd_rx`

## Requirements
- R1: While `csN` is low, each falling edge of `sclk` samples `sdi`, most significant bit first. The first 24 bits form one frame: bits 23..16 appear on `cmdCode` and bits 15..0 appear on `cmdData`.
- R2: `cmdValid` is high for exactly one clock cycle per complete frame. `cmdCode` and `cmdData` are valid in that cycle.
- R3: Once 24 bits have been taken, all further clock edges are ignored until `csN` returns high. Those bits belong to the next device, and they cause no strobe and no change of state here.
- R4: If ready is enabled when a frame starts, `readyN` goes low in the same cycle as that frame's `cmdValid`.
- R5: `readyN` returns high once the synchronized `csN` is high, and it stays high while the device is deselected.
- R6: Command code 0x03 (power control) writes payload bit 0 into the ready-enable flag. The new value applies from the next frame on. While the flag is 0, `readyN` stays high.
- R7: Command code 0x02 (software clear) sets the ready-enable flag back to 1.
- R8: Any other code, including the no-op code 0x00, still produces a strobe but leaves the ready-enable flag unchanged.
- R9: If `csN` rises before 24 bits have been received, the partial frame is dropped without a strobe. The next selection starts counting again from bit one.
- R10: After reset, `readyN` is high, `cmdValid` is low and the ready-enable flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low device select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous; data is taken on its falling edge |
| sdi | input | 1 | Serial data in, MSB first |
| cmdValid | output | 1 | One-cycle strobe marking a complete frame |
| cmdCode | output | 8 | Command code of the last frame |
| cmdData | output | 16 | Payload of the last frame |
| readyN | output | 1 | Active-low select for the next device in the chain |

## Verification
The assertions check the following on every cycle:
- the strobe is a single-cycle pulse;
- the bit counter never passes the frame length;
- `readyN` is released after deselection;
- `readyN` only falls together with a strobe;
- `readyN` only falls while the enable flag was set;
- no strobe appears while the device is deselected.

Only the bench scenarios can show the data itself, because they need whole sequences of frames:
- correct bit order and field split;
- that the bits after the 24th are not consumed;
- that an aborted frame leaves no trace;
- how power-control, clear and no-op frames change the ready behaviour of later frames.

// File: rtl/chain_cmd_pkg.sv
package chain_cmd_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic shiftEn;   // take one serial bit
    logic frameEnd;  // this bit completes the frame
    logic deselect;  // synchronized select is high
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HOLD = 2'd2
  } rx_state_t;

endpackage

// File: rtl/chain_cmd_sync.sv
module chain_cmd_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= RST_VAL;
        else       stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= RST_VAL;
        else       stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/chain_cmd_ctrl.sv
module chain_cmd_ctrl
  import chain_cmd_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int CNT_W = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csSync,
  input  logic             sclkSync,
  output ctrl_strobe_t     strobes,
  output logic [CNT_W-1:0] bitCnt
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  rx_state_t state, stateNext;
  logic sclkPrev;
  logic fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclkSync;
  end

  assign fallEdge = sclkPrev & ~sclkSync;

  always_comb begin
    strobes.deselect = csSync;
    strobes.shiftEn  = fallEdge && !csSync && (state != ST_HOLD);
    strobes.frameEnd = strobes.shiftEn && (bitCnt == LAST_BIT);
  end

  always_comb begin
    stateNext = state;
    if (csSync) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = strobes.frameEnd ? ST_HOLD : ST_RECV;
        ST_RECV: if (strobes.frameEnd) stateNext = ST_HOLD;
        ST_HOLD: stateNext = ST_HOLD;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (csSync || strobes.frameEnd) bitCnt <= '0;
      else if (strobes.shiftEn)       bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/chain_cmd_dp.sv
module chain_cmd_dp
  import chain_cmd_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int DATA_W = 16,
  parameter int FRAME_W = CMD_W + DATA_W,
  parameter logic [CMD_W-1:0] CODE_CLEAR = 8'h02,
  parameter logic [CMD_W-1:0] CODE_PWR = 8'h03,
  parameter int EN_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobes,
  input  logic              sdiSync,
  output logic              cmdValid,
  output logic [CMD_W-1:0]  cmdCode,
  output logic [DATA_W-1:0] cmdData,
  output logic              readyN,
  output logic              readyEn
);

  logic [FRAME_W-2:0] shiftReg;
  logic [FRAME_W-1:0] frameWord;
  logic [CMD_W-1:0]   newCode;
  logic [DATA_W-1:0]  newData;

  assign frameWord = {shiftReg, sdiSync};
  assign newCode   = frameWord[FRAME_W-1 -: CMD_W];
  assign newData   = frameWord[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      cmdValid <= 1'b0;
      cmdCode  <= '0;
      cmdData  <= '0;
      readyEn  <= 1'b1;
      readyN   <= 1'b1;
    end else begin
      cmdValid <= strobes.frameEnd;
      if (strobes.shiftEn) shiftReg <= frameWord[FRAME_W-2:0];
      if (strobes.frameEnd) begin
        cmdCode <= newCode;
        cmdData <= newData;
        if (newCode == CODE_PWR)        readyEn <= newData[EN_BIT];
        else if (newCode == CODE_CLEAR) readyEn <= 1'b1;
      end
      if (strobes.deselect)                 readyN <= 1'b1;
      else if (strobes.frameEnd && readyEn) readyN <= 1'b0;
    end
  end

endmodule

// File: rtl/chain_cmd_rx.sv
module chain_cmd_rx
  import chain_cmd_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [CMD_W-1:0] CODE_CLEAR = 8'h02,
  parameter logic [CMD_W-1:0] CODE_PWR = 8'h03,
  parameter int EN_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              cmdValid,
  output logic [CMD_W-1:0]  cmdCode,
  output logic [DATA_W-1:0] cmdData,
  output logic              readyN
);

  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_W);

  logic [2:0]       syncOut;
  logic             csSync, sclkSync, sdiSync;
  ctrl_strobe_t     strobes;
  logic [CNT_W-1:0] bitCnt;
  logic             readyEn;

  chain_cmd_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)
  ) sync_i (
    .clk(clk), .rstN(rstN), .din({csN, sclk, sdi}), .dout(syncOut)
  );

  assign {csSync, sclkSync, sdiSync} = syncOut;

  chain_cmd_ctrl #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .csSync(csSync), .sclkSync(sclkSync),
    .strobes(strobes), .bitCnt(bitCnt)
  );

  chain_cmd_dp #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W),
    .CODE_CLEAR(CODE_CLEAR), .CODE_PWR(CODE_PWR), .EN_BIT(EN_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdiSync(sdiSync),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdData(cmdData),
    .readyN(readyN), .readyEn(readyEn)
  );

endmodule

// File: rtl/chain_cmd_rx_chk.sv
module chain_cmd_rx_chk #(
  parameter int FRAME_W = 24,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             csSync,
  input logic             cmdValid,
  input logic             readyN,
  input logic             readyEn,
  input logic [CNT_W-1:0] bitCnt
);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(FRAME_W));

  a_r5_ready_release: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> readyN);

  a_r4_ready_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> cmdValid);

  a_r6_ready_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> $past(readyEn));

  a_r1_no_strobe_deselected: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !$past(csSync));

endmodule

bind chain_cmd_rx chain_cmd_rx_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .csSync(csSync), .cmdValid(cmdValid),
  .readyN(readyN), .readyEn(readyEn), .bitCnt(bitCnt)
);

// File: tb/chain_cmd_rx_tb_top.sv
module chain_cmd_rx_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic cmdValid;
  logic [7:0] cmdCode;
  logic [15:0] cmdData;
  logic readyN;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  bit expEn = 1'b1;
  logic [23:0] expQ[$];

  always #10 clk = ~clk;

  chain_cmd_rx dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdData(cmdData), .readyN(readyN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: every strobe must match the next queued frame (R1, R2).
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3/R9 unexpected strobe", {cmdCode, cmdData}, 0);
      end else begin
        logic [23:0] e;
        e = expQ.pop_front();
        check({cmdCode, cmdData} == e, "R1 frame fields", {cmdCode, cmdData}, e);
      end
    end
  end

  // Driver: send nBits of first (then second), with select held low.
  task automatic burst(input logic [23:0] first, input int nBits, input logic [23:0] second);
    bit enAtStart;
    enAtStart = expEn;
    if (nBits >= 24) expQ.push_back(first);
    csN = 1'b0;
    waitClk(6);
    for (int i = 0; i < nBits; i++) begin
      sdi = (i < 24) ? first[23 - i] : second[47 - i];
      waitClk(4);
      sclk = 1'b0;
      if (i == 23) begin
        waitClk(6);
        if (enAtStart) check(readyN == 1'b0, "R4 ready low after frame", readyN, 0);
        else           check(readyN == 1'b1, "R6 ready held off", readyN, 1);
        waitClk(4);
      end else begin
        waitClk(4);
      end
      sclk = 1'b1;
    end
    waitClk(6);
    csN = 1'b1;
    waitClk(8);
    check(readyN == 1'b1, "R5 ready released", readyN, 1);
    if (nBits >= 24) begin
      if (first[23:16] == 8'h03)      expEn = first[0];
      else if (first[23:16] == 8'h02) expEn = 1'b1;
    end
  endtask

  initial begin
    waitClk(5);
    check(readyN == 1'b1, "R10 reset readyN", readyN, 1);
    check(cmdValid == 1'b0, "R10 reset cmdValid", cmdValid, 0);
    rstN = 1'b1;
    waitClk(5);
    check(readyN == 1'b1 && cmdValid == 1'b0, "R10 after reset", {readyN, cmdValid}, 2);

    burst(24'h11A5C3, 24, 24'h0);                  // R1 R2 R4 R5; R10 enable default
    burst(24'h7E8001, 48, 24'h030000);             // R3: second frame belongs to next device
    burst(24'h030000, 10, 24'h0);                  // R9: aborted frame
    burst(24'h221234, 24, 24'h0);                  // R9 recount; R3 enable untouched
    burst(24'h030000, 24, 24'h0);                  // R6: disable, applies next frame
    burst(24'h00FFFF, 24, 24'h0);                  // R8 no-op keeps flag clear
    burst(24'h408001, 24, 24'h0);                  // R8 other code keeps flag clear
    burst(24'h020000, 24, 24'h0);                  // R7 clear restores enable
    burst(24'h5A0F0F, 24, 24'h0);                  // R7 confirm enabled
    burst(24'h030001, 24, 24'h0);                  // R6 write 1 keeps enabled
    burst(24'hC3FFFE, 24, 24'h0);                  // R6 confirm enabled
    waitClk(10);
    check(expQ.size() == 0, "R2 all frames strobed", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitClk(150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule